// File: doc/BRIEF.md
# Six-Pin Parallel Port Controller

This block is a small memory-mapped parallel I/O port with six pins. Software sees two registers on a plain register bus: a data latch and a per-pin direction register. For every pin the block presents an output level and an output-enable towards the pad. It also takes in the raw pad level, which passes through a synchronizer before software can read it.

A read of the data register is assembled bit by bit. A pin set as an output returns its latched value, and a pin set as an input returns its synchronized pad level. Two pins are fixed in function. Pin 5 can only be an input: its direction bit is not kept and reads as zero. Pin 4 can only be an output: it is always driven from its latch bit, and whatever its direction bit holds has no effect on it. Writes to the data register always update the latch, whatever the direction. Software can therefore preload a level before it turns a driver on.

Top module: `gpio6_port`

## Requirements
- R1: After reset the data latch and all direction bits are zero. pin_out reads 6'h00 and pin_oe reads 6'b010000, so only the output-only pin 4 is driven. Both registers read back 8'h00.
- R2: A write with bus_we high at address 0 stores wdata[5:0] in the data latch on that clock edge, whatever the direction bits hold. From then on pin_out[4:0] shows latch bits 4:0, while pin_out[5] is always 0.
- R3: For pins 0 to 3, direction bit 1 sets pin_oe high, and a data read of that bit returns the latch bit. Direction bit 0 sets pin_oe low.
- R4: For a pin whose direction is input, a data read returns pin_in through a two-flop synchronizer. A level applied before a rising edge shows on bus_rdata after the second rising edge.
- R5: Pin 5 is input-only. pin_oe[5] is always 0, direction bit 5 always reads 0 whatever was written, and data reads of bit 5 always return the synchronized pin level.
- R6: Pin 4 is output-only. pin_oe[4] is always 1, and data reads of bit 4 return latch bit 4. Direction bit 4 is stored and reads back, but it changes neither pin_oe[4] nor the read path.
- R7: Address 0 selects the data register and address 1 the direction register. Bits 7:6 of every read are 0. Addresses 2 and 3 read 8'h00, and writes to them change no state.
- R8: A cycle with bus_we low changes neither pin_out nor pin_oe, whatever bus_addr and bus_wdata hold.
- R9: A value written to the data latch while a pin is an input is the value that pin drives and reads back once its direction is later set to output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pin_in | input | 6 | Raw pad levels |
| pin_out | output | 6 | Level to drive on each pad |
| pin_oe | output | 6 | Output-driver enable for each pad |

## Verification
The hardest case to reach from the ports is a bit whose read source changes, from the synchronized pad to the latch. It needs a latch value written while the bit was an input that differs from the pad level at the moment the direction flips. The stimulus table first writes a data pattern while pins 1 and 3 are inputs, with opposite pad levels applied. It then turns those pins into outputs and checks that the read and pin_out follow the earlier write rather than the pad. A directed step walks a single pad edge through the synchronizer and samples the read both before and after the second clock edge.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;

   typedef enum logic [1:0] {
      PK_BIDIR    = 2'd0,
      PK_IN_ONLY  = 2'd1,
      PK_OUT_ONLY = 2'd2
   } pin_kind_e;

   localparam int unsigned OFS_DATA = 0;
   localparam int unsigned OFS_DIR  = 1;

   function automatic pin_kind_e kind_of(input logic in_only, input logic out_only);
      if (in_only)
         return PK_IN_ONLY;
      else if (out_only)
         return PK_OUT_ONLY;
      else
         return PK_BIDIR;
   endfunction

endpackage

// File: rtl/gpio6_sync.sv
module gpio6_sync #(
   parameter int unsigned W      = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio6_regs.sv
module gpio6_regs #(
   parameter int unsigned       PORT_W       = 6,
   parameter logic [PORT_W-1:0] IN_ONLY_MASK = 6'b100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_data,
   input  logic              wr_dir,
   input  logic [PORT_W-1:0] wval,
   output logic [PORT_W-1:0] latch_q,
   output logic [PORT_W-1:0] dir_q
);
   localparam logic [PORT_W-1:0] DIR_KEEP = ~IN_ONLY_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (wr_data) begin
         latch_q <= wval;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
      end else if (wr_dir) begin
         dir_q <= wval & DIR_KEEP;
      end
   end
endmodule

// File: rtl/gpio6_pin_slice.sv
module gpio6_pin_slice #(
   parameter gpio6_pkg::pin_kind_e KIND = gpio6_pkg::PK_BIDIR
) (
   input  logic lat,
   input  logic dir,
   input  logic pad_sync,
   output logic drv,
   output logic oe,
   output logic rd
);
   generate
      if (KIND == gpio6_pkg::PK_IN_ONLY) begin : g_in
         logic unused_in;
         assign unused_in = lat ^ dir;
         assign drv = 1'b0;
         assign oe  = 1'b0;
         assign rd  = pad_sync;
      end else if (KIND == gpio6_pkg::PK_OUT_ONLY) begin : g_out
         logic unused_out;
         assign unused_out = dir ^ pad_sync;
         assign drv = lat;
         assign oe  = 1'b1;
         assign rd  = lat;
      end else begin : g_bidir
         assign drv = lat;
         assign oe  = dir;
         assign rd  = dir ? lat : pad_sync;
      end
   endgenerate
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port #(
   parameter int unsigned       PORT_W        = 6,
   parameter int unsigned       BUS_W         = 8,
   parameter int unsigned       ADDR_W        = 2,
   parameter int unsigned       SYNC_STAGES   = 2,
   parameter logic [PORT_W-1:0] IN_ONLY_MASK  = 6'b100000,
   parameter logic [PORT_W-1:0] OUT_ONLY_MASK = 6'b010000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] pin_out,
   output logic [PORT_W-1:0] pin_oe
);
   import gpio6_pkg::*;

   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
   localparam int unsigned       PAD_W  = BUS_W - PORT_W;

   generate
      if (BUS_W <= PORT_W) begin : g_chk_bus
         $error("gpio6_port: BUS_W must exceed PORT_W");
      end
      if ((IN_ONLY_MASK & OUT_ONLY_MASK) != '0) begin : g_chk_mask
         $error("gpio6_port: a pin cannot be both input-only and output-only");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("gpio6_port: SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 1) begin : g_chk_addr
         $error("gpio6_port: ADDR_W must be at least 1");
      end
   endgenerate

   logic [PORT_W-1:0] wval;
   logic              hit_data, hit_dir;
   logic [PORT_W-1:0] latch_q, dir_q, pad_sync, rd_bits;
   logic              unused_wdata;

   assign wval         = bus_wdata[PORT_W-1:0];
   assign unused_wdata = ^bus_wdata[BUS_W-1:PORT_W];
   assign hit_data     = bus_we && (bus_addr == A_DATA);
   assign hit_dir      = bus_we && (bus_addr == A_DIR);

   gpio6_regs #(
      .PORT_W       (PORT_W),
      .IN_ONLY_MASK (IN_ONLY_MASK)
   ) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_data (hit_data),
      .wr_dir  (hit_dir),
      .wval    (wval),
      .latch_q (latch_q),
      .dir_q   (dir_q)
   );

   gpio6_sync #(
      .W      (PORT_W),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pad_sync)
   );

   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      localparam pin_kind_e K = kind_of(IN_ONLY_MASK[i], OUT_ONLY_MASK[i]);
      gpio6_pin_slice #(.KIND(K)) slice_i (
         .lat      (latch_q[i]),
         .dir      (dir_q[i]),
         .pad_sync (pad_sync[i]),
         .drv      (pin_out[i]),
         .oe       (pin_oe[i]),
         .rd       (rd_bits[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_DATA)
         bus_rdata = {{PAD_W{1'b0}}, rd_bits};
      else if (bus_addr == A_DIR)
         bus_rdata = {{PAD_W{1'b0}}, dir_q};
   end
endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk #(
   parameter int unsigned PORT_W = 6,
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic [PORT_W-1:0] pin_in,
   input logic [PORT_W-1:0] pin_out,
   input logic [PORT_W-1:0] pin_oe
);
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(0)) |=> pin_out[4:0] == $past(bus_wdata[4:0]));

   p_dir_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(1)) |=> pin_oe[3:0] == $past(bus_wdata[3:0]));

   p_bidir_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(0) && pin_oe[0]) |-> bus_rdata[0] == pin_out[0]);

   p_sync_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && bus_addr == ADDR_W'(0)) |-> bus_rdata[5] == $past(pin_in[5], 2));

   p_in_only_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[5] == 1'b0 && pin_out[5] == 1'b0);

   p_dir5_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(1)) |-> bus_rdata[5] == 1'b0);

   p_out_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[4] && (bus_addr != ADDR_W'(0) || bus_rdata[4] == pin_out[4]));

   p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[BUS_W-1:PORT_W] == '0);

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(pin_out) && $stable(pin_oe));
endmodule

bind gpio6_port gpio6_port_chk #(
   .PORT_W (PORT_W),
   .BUS_W  (BUS_W),
   .ADDR_W (ADDR_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_in    (pin_in),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe)
);

// File: tb/gpio6_port_tb_top.sv
`timescale 1ns/100ps
module gpio6_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [5:0] pin_in = '0;
   logic [5:0] pin_out, pin_oe;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio6_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // {wr, waddr, wdata, pin, raddr, exp_rdata, exp_out, exp_oe}
   localparam int NV = 12;
   localparam logic [38:0] VEC [NV] = '{
      {1'b1, 2'd0, 8'hFF, 6'h00, 2'd0, 8'h10, 6'h1F, 6'h10}, // R2 R6: latch all bits while inputs
      {1'b1, 2'd1, 8'h0F, 6'h00, 2'd0, 8'h1F, 6'h1F, 6'h1F}, // R3: outputs read latch
      {1'b0, 2'd0, 8'h00, 6'h2A, 2'd0, 8'h3F, 6'h1F, 6'h1F}, // R8 R5: no write, pin5 via pad
      {1'b1, 2'd1, 8'hFF, 6'h2A, 2'd1, 8'h1F, 6'h1F, 6'h1F}, // R5 R7: dir bit 5 reads 0
      {1'b1, 2'd1, 8'h00, 6'h15, 2'd0, 8'h15, 6'h1F, 6'h10}, // R4 R6: inputs read pads
      {1'b1, 2'd0, 8'h00, 6'h3F, 2'd0, 8'h2F, 6'h00, 6'h10}, // R2 R4 R6
      {1'b1, 2'd1, 8'h05, 6'h3F, 2'd0, 8'h2A, 6'h00, 6'h15}, // R3 R4: mixed directions
      {1'b1, 2'd2, 8'hFF, 6'h3F, 2'd2, 8'h00, 6'h00, 6'h15}, // R7: unmapped write ignored
      {1'b1, 2'd0, 8'h2A, 6'h0A, 2'd0, 8'h0A, 6'h0A, 6'h15}, // R2 R3 R4
      {1'b1, 2'd1, 8'h10, 6'h00, 2'd1, 8'h10, 6'h0A, 6'h10}, // R6: dir4 stored, no effect
      {1'b1, 2'd1, 8'h0F, 6'h00, 2'd0, 8'h0A, 6'h0A, 6'h1F}, // R9: preloaded latch appears
      {1'b0, 2'd3, 8'hFF, 6'h00, 2'd3, 8'h00, 6'h0A, 6'h1F}  // R7 R8: unmapped read
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R1: reset state
      check("R1 data read", bus_rdata, 8'h00);
      check("R1 pin_out", {2'b0, pin_out}, 8'h00);
      check("R1 pin_oe", {2'b0, pin_oe}, 8'h10);
      bus_addr = 2'd1;
      #1 check("R1 dir read", bus_rdata, 8'h00);

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         pin_in    = VEC[v][27:22];
         bus_addr  = VEC[v][37:36];
         bus_wdata = VEC[v][35:28];
         bus_we    = VEC[v][38];
         @(posedge clk);
         @(negedge clk) bus_we = 1'b0;
         @(posedge clk);
         @(negedge clk) bus_addr = VEC[v][21:20];
         #1;
         $display("vector %0d", v);
         check("R2/R3/R4/R5/R6/R7/R9 table rdata", bus_rdata, VEC[v][19:12]);
         check("R2/R8/R9 table pin_out", {2'b0, pin_out}, {2'b0, VEC[v][11:6]});
         check("R3/R5/R6/R8 table pin_oe", {2'b0, pin_oe}, {2'b0, VEC[v][5:0]});
      end

      // R4: two-edge synchronizer latency on pin 0
      @(negedge clk);
      bus_addr = 2'd1; bus_wdata = 8'h00; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 2'd0; pin_in = 6'h01;
      @(posedge clk);
      @(negedge clk) #1 check("R4 one edge after pin change", {7'b0, bus_rdata[0]}, 8'h00);
      @(posedge clk);
      @(negedge clk) #1 check("R4 two edges after pin change", {7'b0, bus_rdata[0]}, 8'h01);

      // R8: write data present but enable low
      @(negedge clk);
      bus_addr = 2'd0; bus_wdata = 8'h15; bus_we = 1'b0;
      @(posedge clk);
      @(negedge clk) #1 check("R8 pin_out held", {2'b0, pin_out}, 8'h0A);

      // R1: reset in mid-run clears everything
      @(negedge clk);
      bus_addr = 2'd1; bus_wdata = 8'h0F; bus_we = 1'b1;
      @(negedge clk) bus_we = 1'b0;
      rst_n = 1'b0;
      #1;
      check("R1 mid-run pin_out", {2'b0, pin_out}, 8'h00);
      check("R1 mid-run pin_oe", {2'b0, pin_oe}, 8'h10);
      check("R1 mid-run dir read", bus_rdata, 8'h00);
      @(negedge clk) rst_n = 1'b1;

      done = 1'b1;
      summary();
      $finish;
   end
endmodule